// File: doc/BRIEF.md
# Paged NIC Host Register File

This block is the byte-wide register front end of a legacy Ethernet controller. A host issues single-byte reads and writes on a 5-bit offset. A command register at offset 0 holds start, stop, transmit and remote-DMA request bits. Its top two bits choose which of three register pages answers at every other offset. One offset can therefore mean a ring pointer on one page, a station address byte on another, and a configuration readback on a third.

The block holds the receive ring pointers and the transmit page and byte count. It also holds the remote-DMA start address and byte count, the receive, transmit and data configuration bytes, six station address bytes and eight multicast filter bytes. An interrupt status byte and a mask byte drive one interrupt line. A transmit command raises a one-cycle send request toward the packet engine, with the transmit page and length on their own ports. Packet memory and framing sit outside the block.

Top module: `paged_nic_regs`

## Requirements
- R1: Offset 0 is the command register on every page. Command bits 7:6 select the page for offsets 1 to 31: 0, 1 or 2. Value 3 selects a page with no registers, so its reads return 0x00 and its writes are ignored. Only a command write changes the page.
- R2: After reset, the command reads 0x22, the mask 0x00 and the status 0x80 (bit 7 is the reset flag). All eight multicast bytes read 0xFF and every other register reads 0x00.
- R3: Writing status (page 0, offset 7) clears each status bit 6:0 whose written bit is 1. All other status bits keep their value, and bit 7 is never touched by such a write.
- R4: irq is high exactly when status bits 6:0 ANDed with the mask are nonzero. It changes on the same clock edge as the status or mask change that causes it, so status bit 7 never raises irq.
- R5: A command write with bit 0 (stop) clear clears status bit 7. A command write with bit 0 set leaves it alone.
- R6: A command write with stop clear and bit 3 (remote read) or bit 4 (remote write) set, while the remote byte count is zero, sets status bit 6.
- R7: The 16-bit transmit count (page 0 offsets 5 low and 6 high), remote start (offsets 8 and 9) and remote count (offsets 10 and 11) are each written a byte at a time. A byte write changes only its own half. These values appear on tx_len, rdma_addr and rdma_len. The transmit page (offset 4) appears on tx_page.
- R8: A command write with stop clear and bit 2 set makes tx_req high for exactly the one cycle after the write. The same write sets the transmit status (page 0 offset 4 read) to 0x01 and sets status bit 1. The command is stored with bit 2 cleared.
- R9: Page 1 maps station address bytes at offsets 1 to 6, the current page at offset 7 and multicast bytes at offsets 8 to 15, all readable and writable.
- R10: Page 0 writes: offset 1 ring start, 2 ring stop, 3 boundary, 12 receive config, 13 transmit config, 14 data config, 15 mask. Page 0 reads return the boundary at 3, the transmit status at 4 and the status at 7. Page 2 reads return ring start at 1, ring stop at 2, transmit page at 4, receive config at 12, transmit config at 13, data config at 14 and mask at 15.
- R11: Reads of offsets that the current page does not map return 0x00, and writes to them change nothing.
- R12: Read data is registered: rdata shows the addressed register in the cycle after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_req | output | 1 | One-cycle send request |
| tx_page | output | 8 | Transmit start page |
| tx_len | output | 16 | Transmit byte count |
| rdma_addr | output | 16 | Remote-DMA start address |
| rdma_len | output | 16 | Remote-DMA byte count |

## Verification
The hardest state to reach is a pending status bit that the mask hides. The stimulus triggers a zero-count remote request while only the transmit-done bit is unmasked, and checks that irq stays low. It then enables that bit's mask and checks that irq rises with no status change. Page aliasing is exercised by writing through one page and reading back through another, including the empty fourth page. The reset flag is kept alive by a stop-set command so that its exemption from irq can be observed with a full mask.

// File: rtl/paged_nic_pkg.sv
package paged_nic_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {PG0 = 2'd0, PG1 = 2'd1, PG2 = 2'd2, PG3 = 2'd3} page_e;

  // offsets shared by several pages
  localparam logic [ADDR_W-1:0] OFS_CMD      = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RSTART   = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_RSTOP    = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_BNDY     = 5'h03;
  localparam logic [ADDR_W-1:0] OFS_TXPG     = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TXCNT_LO = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_TXCNT_HI = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_STAT     = 5'h07;
  localparam logic [ADDR_W-1:0] OFS_RSA_LO   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RSA_HI   = 5'h09;
  localparam logic [ADDR_W-1:0] OFS_RCNT_LO  = 5'h0A;
  localparam logic [ADDR_W-1:0] OFS_RCNT_HI  = 5'h0B;
  localparam logic [ADDR_W-1:0] OFS_RXCFG    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TXCFG    = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_DCFG     = 5'h0E;
  localparam logic [ADDR_W-1:0] OFS_MASK     = 5'h0F;
  localparam logic [ADDR_W-1:0] OFS_CURPG    = 5'h07;

  // command bits
  localparam int unsigned CB_STOP = 0;
  localparam int unsigned CB_TX   = 2;
  localparam int unsigned CB_RRD  = 3;
  localparam int unsigned CB_RWR  = 4;

  // status bits
  localparam int unsigned SB_TXDONE = 1;
  localparam int unsigned SB_RDMA   = 6;
  localparam int unsigned SB_RESET  = 7;

  localparam logic [BYTE_W-1:0] CMD_RESET  = 8'h22;
  localparam logic [BYTE_W-1:0] STAT_RESET = 8'h80;
  localparam logic [BYTE_W-1:0] IRQ_BITS   = 8'h7F;
  localparam logic [BYTE_W-1:0] TXSTAT_OK  = 8'h01;
endpackage

// File: rtl/nic_wide_reg.sv
module nic_wide_reg #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [WIDTH/2-1:0] din,
  output logic [WIDTH-1:0]   q
);
  localparam int unsigned HALF = WIDTH / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= INIT;
    end else begin
      if (wr_lo) q[HALF-1:0]     <= din;
      if (wr_hi) q[WIDTH-1:HALF] <= din;
    end
  end
endmodule

// File: rtl/nic_addr_bank.sv
module nic_addr_bank #(
  parameter int unsigned NBYTES = 6,
  parameter logic [7:0]  INIT   = 8'h00,
  localparam int unsigned IW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    din,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  logic [7:0] bytes_w [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst)                                        b_q <= INIT;
      else if (wr_en && (wr_idx == IW'(i)))           b_q <= din;
    end
    assign bytes_w[i] = b_q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NBYTES; k++) begin
      if (rd_idx == IW'(k)) rd_data = bytes_w[k];
    end
  end
endmodule

// File: rtl/nic_status_ctrl.sv
module nic_status_ctrl
  import paged_nic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              stat_we,
  input  logic              mask_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rcnt_zero,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] mask_q,
  output logic [BYTE_W-1:0] txstat_q,
  output logic              irq,
  output logic              tx_req
);
  logic [BYTE_W-1:0] cmd_n, stat_n, mask_n, txstat_n;
  logic              tx_n;

  always_comb begin
    cmd_n    = cmd_q;
    stat_n   = stat_q;
    mask_n   = mask_q;
    txstat_n = txstat_q;
    tx_n     = 1'b0;
    if (cmd_we) begin
      cmd_n = wdata;
      if (!wdata[CB_STOP]) begin
        stat_n[SB_RESET] = 1'b0;
        if ((wdata[CB_RRD] || wdata[CB_RWR]) && rcnt_zero) stat_n[SB_RDMA] = 1'b1;
        if (wdata[CB_TX]) begin
          tx_n               = 1'b1;
          txstat_n           = TXSTAT_OK;
          stat_n[SB_TXDONE]  = 1'b1;
          cmd_n[CB_TX]       = 1'b0;
        end
      end
    end
    if (stat_we) stat_n = stat_n & ~(wdata & IRQ_BITS);
    if (mask_we) mask_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_RESET;
      stat_q   <= STAT_RESET;
      mask_q   <= '0;
      txstat_q <= '0;
      irq      <= 1'b0;
      tx_req   <= 1'b0;
    end else begin
      cmd_q    <= cmd_n;
      stat_q   <= stat_n;
      mask_q   <= mask_n;
      txstat_q <= txstat_n;
      irq      <= |(stat_n & mask_n & IRQ_BITS);
      tx_req   <= tx_n;
    end
  end
endmodule

// File: rtl/paged_nic_regs.sv
module paged_nic_regs
  import paged_nic_pkg::*;
#(
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned STATION_BYTES = 6,
  parameter int unsigned MCAST_BYTES   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq,
  output logic              tx_req,
  output logic [BYTE_W-1:0] tx_page,
  output logic [CNT_W-1:0]  tx_len,
  output logic [CNT_W-1:0]  rdma_addr,
  output logic [CNT_W-1:0]  rdma_len
);
  localparam int unsigned SIW = (STATION_BYTES > 1) ? $clog2(STATION_BYTES) : 1;
  localparam int unsigned MIW = (MCAST_BYTES > 1) ? $clog2(MCAST_BYTES) : 1;
  localparam logic [ADDR_W-1:0] STA_FIRST = 5'h01;
  localparam logic [ADDR_W-1:0] STA_LAST  = ADDR_W'(STATION_BYTES);
  localparam logic [ADDR_W-1:0] MC_FIRST  = 5'h08;
  localparam logic [ADDR_W-1:0] MC_LAST   = ADDR_W'(8 + MCAST_BYTES - 1);

  logic [BYTE_W-1:0] cmd_q, stat_q, mask_q, txstat_q;
  logic [BYTE_W-1:0] rstart_q, rstop_q, bndy_q, txpg_q, curpg_q;
  logic [BYTE_W-1:0] rxcfg_q, txcfg_q, dcfg_q;
  logic [BYTE_W-1:0] sta_rd, mc_rd, rd_mux;
  page_e             page;
  logic              cmd_we, p0_we, p1_we, in_sta, in_mc;
  logic [SIW-1:0]    sta_idx;
  logic [MIW-1:0]    mc_idx;

  assign page   = page_e'(cmd_q[7:6]);
  assign cmd_we = wr_en && (addr == OFS_CMD);
  assign p0_we  = wr_en && (addr != OFS_CMD) && (page == PG0);
  assign p1_we  = wr_en && (addr != OFS_CMD) && (page == PG1);
  assign in_sta = (addr >= STA_FIRST) && (addr <= STA_LAST);
  assign in_mc  = (addr >= MC_FIRST) && (addr <= MC_LAST);
  assign sta_idx = SIW'(addr - STA_FIRST);
  assign mc_idx  = MIW'(addr - MC_FIRST);

  nic_status_ctrl u_stat (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (cmd_we),
    .stat_we  (p0_we && (addr == OFS_STAT)),
    .mask_we  (p0_we && (addr == OFS_MASK)),
    .wdata    (wdata),
    .rcnt_zero(rdma_len == '0),
    .cmd_q    (cmd_q),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .txstat_q (txstat_q),
    .irq      (irq),
    .tx_req   (tx_req)
  );

  nic_wide_reg #(.WIDTH(CNT_W)) u_txcnt (
    .clk(clk), .rst(rst),
    .wr_lo(p0_we && (addr == OFS_TXCNT_LO)),
    .wr_hi(p0_we && (addr == OFS_TXCNT_HI)),
    .din(wdata), .q(tx_len));

  nic_wide_reg #(.WIDTH(CNT_W)) u_rsa (
    .clk(clk), .rst(rst),
    .wr_lo(p0_we && (addr == OFS_RSA_LO)),
    .wr_hi(p0_we && (addr == OFS_RSA_HI)),
    .din(wdata), .q(rdma_addr));

  nic_wide_reg #(.WIDTH(CNT_W)) u_rcnt (
    .clk(clk), .rst(rst),
    .wr_lo(p0_we && (addr == OFS_RCNT_LO)),
    .wr_hi(p0_we && (addr == OFS_RCNT_HI)),
    .din(wdata), .q(rdma_len));

  nic_addr_bank #(.NBYTES(STATION_BYTES), .INIT(8'h00)) u_station (
    .clk(clk), .rst(rst),
    .wr_en(p1_we && in_sta), .wr_idx(sta_idx), .din(wdata),
    .rd_idx(sta_idx), .rd_data(sta_rd));

  nic_addr_bank #(.NBYTES(MCAST_BYTES), .INIT(8'hFF)) u_mcast (
    .clk(clk), .rst(rst),
    .wr_en(p1_we && in_mc), .wr_idx(mc_idx), .din(wdata),
    .rd_idx(mc_idx), .rd_data(mc_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      rstart_q <= '0; rstop_q <= '0; bndy_q <= '0; txpg_q <= '0;
      rxcfg_q  <= '0; txcfg_q <= '0; dcfg_q <= '0; curpg_q <= '0;
    end else begin
      if (p0_we) begin
        case (addr)
          OFS_RSTART: rstart_q <= wdata;
          OFS_RSTOP:  rstop_q  <= wdata;
          OFS_BNDY:   bndy_q   <= wdata;
          OFS_TXPG:   txpg_q   <= wdata;
          OFS_RXCFG:  rxcfg_q  <= wdata;
          OFS_TXCFG:  txcfg_q  <= wdata;
          OFS_DCFG:   dcfg_q   <= wdata;
          default: ;
        endcase
      end
      if (p1_we && (addr == OFS_CURPG)) curpg_q <= wdata;
    end
  end

  assign tx_page = txpg_q;

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_CMD) begin
      rd_mux = cmd_q;
    end else begin
      case (page)
        PG0: case (addr)
          OFS_BNDY: rd_mux = bndy_q;
          OFS_TXPG: rd_mux = txstat_q;
          OFS_STAT: rd_mux = stat_q;
          default:  rd_mux = '0;
        endcase
        PG1: begin
          if (in_sta)                   rd_mux = sta_rd;
          else if (addr == OFS_CURPG)   rd_mux = curpg_q;
          else if (in_mc)               rd_mux = mc_rd;
        end
        PG2: case (addr)
          OFS_RSTART: rd_mux = rstart_q;
          OFS_RSTOP:  rd_mux = rstop_q;
          OFS_TXPG:   rd_mux = txpg_q;
          OFS_RXCFG:  rd_mux = rxcfg_q;
          OFS_TXCFG:  rd_mux = txcfg_q;
          OFS_DCFG:   rd_mux = dcfg_q;
          OFS_MASK:   rd_mux = mask_q;
          default:    rd_mux = '0;
        endcase
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/paged_nic_regs_chk.sv
module paged_nic_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [4:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       tx_req,
  input logic [7:0] cmd_q,
  input logic [7:0] mask_q
);
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> !tx_req); // R8
  AST_TX_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> $past(wr_en && addr == 5'h00 && wdata[2] && !wdata[0])); // R8
  AST_TX_BIT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> !cmd_q[2]); // R8
  AST_CLEAR_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'h07 && cmd_q[7:6] == 2'd0 && wdata[6:0] == 7'h7F) |=> !irq); // R3
  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mask_q == 8'h00) |-> !irq); // R4
  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 5'h00) |=> $stable(cmd_q[7:6])); // R1
endmodule

bind paged_nic_regs paged_nic_regs_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .tx_req(tx_req), .cmd_q(cmd_q), .mask_q(mask_q));

// File: tb/paged_nic_regs_bench.sv
module paged_nic_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, tx_page;
  logic        irq, tx_req;
  logic [15:0] tx_len, rdma_addr, rdma_len;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  paged_nic_regs u_paged_nic_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_req(tx_req),
    .tx_page(tx_page), .tx_len(tx_len), .rdma_addr(rdma_addr), .rdma_len(rdma_len));

  // {read, offset, data, expected}
  localparam int NV = 32;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'h01, 8'h46, 8'h00}, {1'b0, 5'h02, 8'h80, 8'h00},
    {1'b0, 5'h0C, 8'h1C, 8'h00}, {1'b0, 5'h0D, 8'h02, 8'h00},
    {1'b0, 5'h0E, 8'h48, 8'h00}, {1'b0, 5'h03, 8'h4C, 8'h00},
    {1'b1, 5'h03, 8'h00, 8'h4C}, {1'b1, 5'h01, 8'h00, 8'h00},
    {1'b0, 5'h00, 8'hA2, 8'h00}, {1'b1, 5'h00, 8'h00, 8'hA2},
    {1'b1, 5'h01, 8'h00, 8'h46}, {1'b1, 5'h02, 8'h00, 8'h80},
    {1'b1, 5'h0C, 8'h00, 8'h1C}, {1'b1, 5'h0D, 8'h00, 8'h02},
    {1'b1, 5'h0E, 8'h00, 8'h48}, {1'b1, 5'h0F, 8'h00, 8'hFF},
    {1'b0, 5'h01, 8'h11, 8'h00}, {1'b1, 5'h01, 8'h00, 8'h46},
    {1'b0, 5'h00, 8'h62, 8'h00}, {1'b0, 5'h01, 8'h52, 8'h00},
    {1'b0, 5'h06, 8'h56, 8'h00}, {1'b0, 5'h07, 8'h4D, 8'h00},
    {1'b0, 5'h08, 8'h00, 8'h00}, {1'b1, 5'h01, 8'h00, 8'h52},
    {1'b1, 5'h06, 8'h00, 8'h56}, {1'b1, 5'h07, 8'h00, 8'h4D},
    {1'b1, 5'h08, 8'h00, 8'h00}, {1'b1, 5'h0F, 8'h00, 8'hFF},
    {1'b1, 5'h10, 8'h00, 8'h00}, {1'b0, 5'h00, 8'h22, 8'h00},
    {1'b1, 5'h07, 8'h00, 8'h00}, {1'b1, 5'h03, 8'h00, 8'h4C}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    check("R2 irq", 16'(irq), 16'h0);
    check("R2 tx_req", 16'(tx_req), 16'h0);
    rd(5'h00, v); check("R2 command", 16'(v), 16'h22);
    check("R12 rdata after read", 16'(rdata), 16'h22);
    rd(5'h07, v); check("R2 status", 16'(v), 16'h80);
    check("R2 rdma_len", rdma_len, 16'h0);
    // R4: reset flag never raises irq even with full mask
    wr(5'h0F, 8'hFF);
    check("R4 bit7 exempt", 16'(irq), 16'h0);
    // R5: stop-set command keeps reset flag
    wr(5'h00, 8'h21);
    rd(5'h07, v); check("R5 stop set keeps flag", 16'(v), 16'h80);

    // table: R1 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        rd(VEC[i][20:16], v);
        check($sformatf("table R1 R9 R10 R11 step %0d", i), 16'(v), 16'(VEC[i][7:0]));
      end else begin
        wr(VEC[i][20:16], VEC[i][15:8]);
      end
    end

    // R7 byte halves
    wr(5'h05, 8'h34); wr(5'h06, 8'h12);
    check("R7 tx_len", tx_len, 16'h1234);
    wr(5'h05, 8'h99);
    check("R7 low half only", tx_len, 16'h1299);
    wr(5'h04, 8'h40);
    check("R7 tx_page", 16'(tx_page), 16'h0040);

    // R8 transmit
    wr(5'h0F, 8'h02);
    wr(5'h00, 8'h26);
    check("R8 tx_req pulse", 16'(tx_req), 16'h1);
    check("R8 tx_len", tx_len, 16'h1299);
    check("R4 irq on tx done", 16'(irq), 16'h1);
    @(negedge clk);
    check("R8 tx_req one cycle", 16'(tx_req), 16'h0);
    rd(5'h00, v); check("R8 command bit2 cleared", 16'(v), 16'h22);
    rd(5'h04, v); check("R8 tx status", 16'(v), 16'h01);
    rd(5'h07, v); check("R8 status bit1", 16'(v), 16'h02);

    // R3 write-one-to-clear
    wr(5'h07, 8'h01);
    rd(5'h07, v); check("R3 other bits kept", 16'(v), 16'h02);
    check("R3 irq kept", 16'(irq), 16'h1);
    wr(5'h07, 8'h02);
    check("R3 irq cleared", 16'(irq), 16'h0);
    rd(5'h07, v); check("R3 status cleared", 16'(v), 16'h00);

    // R6 zero-count remote request, masked then unmasked
    wr(5'h00, 8'h0A);
    rd(5'h07, v); check("R6 remote done set", 16'(v), 16'h40);
    check("R4 masked pending", 16'(irq), 16'h0);
    wr(5'h0F, 8'h40);
    check("R4 unmask raises irq", 16'(irq), 16'h1);
    wr(5'h07, 8'h40);
    check("R3 remote done cleared", 16'(irq), 16'h0);

    // R6 nonzero count does not set; R7 remote regs
    wr(5'h0A, 8'h05);
    check("R7 rdma_len", rdma_len, 16'h0005);
    wr(5'h08, 8'hAA); wr(5'h09, 8'hBB);
    check("R7 rdma_addr", rdma_addr, 16'hBBAA);
    wr(5'h00, 8'h12);
    rd(5'h07, v); check("R6 nonzero count no set", 16'(v), 16'h00);

    // R1 R11 empty page 3
    wr(5'h00, 8'hE2);
    rd(5'h00, v); check("R1 command on page3", 16'(v), 16'hE2);
    wr(5'h03, 8'h77);
    rd(5'h03, v); check("R11 page3 read zero", 16'(v), 16'h00);
    wr(5'h00, 8'h22);
    rd(5'h03, v); check("R11 page3 write ignored", 16'(v), 16'h4C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule